// File: doc/BRIEF.md
# LPC Host Bus Cycle Engine

This block is the bus-side half of a Low Pin Count host controller. A front end hands it one command (cycle kind, direction, address mode, start address, byte count and a sync wait limit) with a single-clock start pulse. The engine then runs one complete bus cycle per byte on the four-bit multiplexed LAD bus and the active-low frame strobe. Every transferred byte gets its own start, type, address and sync phases. The address either stays fixed or steps by one per byte.

Three cycle kinds are handled: I/O, memory and firmware hub. For writes, the engine pulls each byte from the front end with a take strobe. For reads, it returns each byte with a valid strobe. A done pulse closes the command. An error level tells the front end whether the slave signalled an error, the sync wait limit ran out, or the command was empty. The current state code is always visible on a port, so a front end can report the bus position. The engine runs on the LPC clock and has a synchronous active-low reset.

Top module: `lpc_cycle_engine`

## Requirements
- R1: While reset is held low and in the first cycle after it, `state_o` is 0 (idle), `lframe_n_o` is 1, and `lad_oe_o`, `done_o`, `error_o`, `rd_valid_o` and `wr_take_o` are all 0.
- R2: `state_o` uses these codes: 0 idle, 1 start, 2 type/direction, 3 address, 4 memory size, 5 write data, 6 host turnaround, 7 sync, 8 read data, 9 slave turnaround, 10 abort. `cmd_kind_i` selects the cycle kind: 0 I/O, 1 memory, 2 firmware hub (3 acts as I/O).
- R3: Each byte cycle opens with one start clock. In that clock `lframe_n_o` is 0 and LAD is driven to 0000 for I/O and memory, 1101 for a firmware hub read and 1110 for a firmware hub write. `lframe_n_o` is 0 in no other state except abort.
- R4: The type/direction clock drives 0000 for an I/O read, 0010 for an I/O write, 0100 for a memory read and 0110 for a memory write. For firmware hub cycles it drives address bits 31:28 as the device select nibble.
- R5: The address is sent most significant nibble first: 4 nibbles of bits 15:0 for I/O, 8 nibbles of bits 31:0 for memory, 7 nibbles of bits 27:0 for firmware hub. Firmware hub cycles then spend one memory size clock driving 0000.
- R6: A write sends its data byte low nibble first over two clocks. Every cycle then performs the host turnaround: 1111 driven for one clock, then LAD released for one clock.
- R7: In a read, after a ready sync the engine samples two data nibbles from `lad_i`, low nibble first. It presents the byte on `rd_byte_o` with a one-clock `rd_valid_o` in the following clock.
- R8: LAD is released (`lad_oe_o` 0) throughout sync, read data and the two slave turnaround clocks. After the turnaround, the engine either starts the next byte or returns to idle with a one-clock `done_o`.
- R9: A command of N bytes runs N byte cycles. In incrementing mode (`cmd_incr_i` 1) the address rises by one per byte; in single mode every byte uses the start address.
- R10: During sync, `lad_i` 0000 means ready. 1010 means error: the engine finishes the slave turnaround, skips the remaining bytes and ends with `error_o` 1. Any other value (0101 and 0110 in normal use) is a wait.
- R11: With limit L, the engine aborts when a sync clock showing neither ready nor error is seen while L such clocks have already passed in that sync phase (L+1 sync clocks in all). Abort holds `lframe_n_o` 0 and drives 1111 for 4 clocks, then idles with `done_o` and `error_o` 1. A ready or error on the last allowed clock takes precedence.
- R12: A start with a byte count of 0 causes no bus activity. `done_o` and `error_o` rise in the next clock and the state stays idle.
- R13: `wr_take_o` is 1 during the start clock of each write byte; `wr_byte_i` is captured at the end of that clock. `error_o` keeps its value from one done until the next start with a nonzero byte count clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LPC clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Command start pulse, accepted in idle |
| cmd_write_i | input | 1 | 1 write, 0 read |
| cmd_kind_i | input | 2 | Cycle kind: 0 I/O, 1 memory, 2 firmware hub |
| cmd_incr_i | input | 1 | 1 incrementing address, 0 single address |
| addr_i | input | 32 | Start address |
| len_i | input | LEN_W | Byte count |
| sync_limit_i | input | LIMIT_W | Allowed sync wait clocks per byte |
| wr_byte_i | input | 8 | Next write byte from the front end |
| wr_take_o | output | 1 | Write byte captured this clock |
| rd_byte_o | output | 8 | Received byte |
| rd_valid_o | output | 1 | Received byte valid |
| done_o | output | 1 | Command finished |
| error_o | output | 1 | Last command ended in error |
| state_o | output | 4 | Current state code |
| lad_o | output | 4 | LAD value driven by the host |
| lad_oe_o | output | 1 | Host drives LAD |
| lframe_n_o | output | 1 | Active-low frame strobe |
| lad_i | input | 4 | LAD value seen on the bus |

## Verification
The sync wait limit and the slave's sync answer can land on the same clock. This happens when the slave shows its final ready or error code on exactly the clock where the wait count reaches the limit. The bench sets up this coincidence by making the number of wait nibbles equal to the limit, once ending in ready and once in error. It judges the result from the full per-clock trace of state and LAD: the expected trace goes through read data or slave turnaround and never enters abort. A separate run shows one more wait clock and checks that abort does follow.

// File: rtl/lpc_eng_pkg.sv
// Package: shared state codes, cycle kinds and helpers for the LPC cycle engine.
// Assumes: state codes are visible to the front end and must keep their values.
package lpc_eng_pkg;

    localparam int ADDR_W = 32;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_START = 4'd1,
        ST_TYPE  = 4'd2,
        ST_ADDR  = 4'd3,
        ST_MSIZE = 4'd4,
        ST_WDATA = 4'd5,
        ST_TARH  = 4'd6,
        ST_SYNC  = 4'd7,
        ST_RDATA = 4'd8,
        ST_TARS  = 4'd9,
        ST_ABORT = 4'd10
    } eng_state_t;

    typedef enum logic [1:0] {
        KIND_IO  = 2'd0,
        KIND_MEM = 2'd1,
        KIND_FWH = 2'd2
    } cyc_kind_t;

    // Index of the last address nibble for a cycle kind (nibble count minus one).
    function automatic logic [2:0] last_addr_nib(cyc_kind_t k);
        case (k)
            KIND_MEM: return 3'd7;
            KIND_FWH: return 3'd6;
            default:  return 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/lpc_addr_gen.sv
// Module: holds the address of the current byte cycle.
// Loads the start address on command accept and steps by one per byte when the
// command asked for incrementing mode; otherwise the address is left alone.
module lpc_addr_gen
    import lpc_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              step_i,
    input  logic              incr_i,
    output logic [ADDR_W-1:0] addr_o
);

    // Address register: load, optional step, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_o <= '0;
        else if (load_i)
            addr_o <= base_i;
        else if (step_i && incr_i)
            addr_o <= addr_o + ADDR_W'(1);
    end

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !(step_i && incr_i)) |=> $stable(addr_o));

endmodule

// File: rtl/lpc_sync_watch.sv
// Module: counts wait clocks inside one sync phase and flags expiry.
// Assumes limit_i is stable while active_i is high (latched by the caller).
// Expiry is raised on a stalled clock once limit_i stalls have already passed.
module lpc_sync_watch #(
    parameter int LIMIT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active_i,
    input  logic               stall_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               expire_o
);

    logic [LIMIT_W-1:0] cnt_q;

    // Expiry: a stalled clock with the budget already spent.
    always_comb expire_o = active_i && stall_i && (cnt_q == limit_i);

    // Wait counter: cleared outside sync, counts stalled clocks inside it.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i)
            cnt_q <= '0;
        else if (stall_i && !expire_o)
            cnt_q <= cnt_q + LIMIT_W'(1);
    end

    // R11
    wait_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (cnt_q <= limit_i));

endmodule

// File: rtl/lpc_drive_mux.sv
// Module: combinational bus driver. Chooses the LAD nibble, its enable and the
// frame strobe from the engine state, phase counter, latched command and address.
// Assumes phase_i stays within the nibble count of the current state.
module lpc_drive_mux
    import lpc_eng_pkg::*;
(
    input  eng_state_t        state_i,
    input  logic [2:0]        phase_i,
    input  cyc_kind_t         kind_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wbyte_i,
    output logic [3:0]        lad_o,
    output logic              lad_oe_o,
    output logic              lframe_n_o
);

    logic [2:0]        nib_idx;
    logic [ADDR_W-1:0] shifted;

    // Address nibble select, most significant first.
    always_comb begin
        nib_idx = last_addr_nib(kind_i) - phase_i;
        shifted = addr_i >> {nib_idx, 2'b00};
    end

    // Per-state drive values.
    always_comb begin
        lad_o      = 4'hF;
        lad_oe_o   = 1'b0;
        lframe_n_o = 1'b1;
        case (state_i)
            ST_START: begin
                lframe_n_o = 1'b0;
                lad_oe_o   = 1'b1;
                lad_o      = (kind_i == KIND_FWH) ? (write_i ? 4'hE : 4'hD) : 4'h0;
            end
            ST_TYPE: begin
                lad_oe_o = 1'b1;
                lad_o    = (kind_i == KIND_FWH) ? addr_i[31:28]
                                                : {1'b0, kind_i == KIND_MEM, write_i, 1'b0};
            end
            ST_ADDR: begin
                lad_oe_o = 1'b1;
                lad_o    = shifted[3:0];
            end
            ST_MSIZE: begin
                lad_oe_o = 1'b1;
                lad_o    = 4'h0;
            end
            ST_WDATA: begin
                lad_oe_o = 1'b1;
                lad_o    = phase_i[0] ? wbyte_i[7:4] : wbyte_i[3:0];
            end
            ST_TARH: begin
                lad_oe_o = !phase_i[0];
                lad_o    = 4'hF;
            end
            ST_ABORT: begin
                lframe_n_o = 1'b0;
                lad_oe_o   = 1'b1;
                lad_o      = 4'hF;
            end
            default: begin
                lad_o    = 4'hF;
                lad_oe_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lpc_cycle_engine.sv
// Module: LPC host bus cycle engine (top). Runs one bus cycle per byte of a
// command: start, type, address, optional memory size, data, turnarounds and
// sync, with a bounded sync wait that ends in a four-clock abort.
// Assumes: start_i is only acted on in idle; command inputs are valid with it;
// wr_byte_i holds the next write byte whenever wr_take_o is high.
module lpc_cycle_engine
    import lpc_eng_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int LIMIT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               cmd_write_i,
    input  logic [1:0]         cmd_kind_i,
    input  logic               cmd_incr_i,
    input  logic [31:0]        addr_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic [LIMIT_W-1:0] sync_limit_i,
    input  logic [7:0]         wr_byte_i,
    output logic               wr_take_o,
    output logic [7:0]         rd_byte_o,
    output logic               rd_valid_o,
    output logic               done_o,
    output logic               error_o,
    output logic [3:0]         state_o,
    output logic [3:0]         lad_o,
    output logic               lad_oe_o,
    output logic               lframe_n_o,
    input  logic [3:0]         lad_i
);

    localparam int ABORT_CLKS = 4;
    localparam logic [2:0] ABORT_LAST = 3'(ABORT_CLKS - 1);

    eng_state_t         state_q;
    logic [2:0]         phase_q;
    logic [LEN_W-1:0]   left_q;
    cyc_kind_t          kind_q;
    logic               wr_q, incr_q;
    logic [LIMIT_W-1:0] limit_q;
    logic [7:0]         wbuf_q;
    logic [3:0]         rlow_q;
    logic               err_q, done_q, rvalid_q;
    logic [7:0]         rbyte_q;
    logic [ADDR_W-1:0]  cur_addr;
    logic               load, step, in_sync, sync_ready, sync_fail, sync_stall, expire;

    // Decode of sync nibble and address control strobes.
    always_comb begin
        sync_ready = (lad_i == 4'h0);
        sync_fail  = (lad_i == 4'hA);
        sync_stall = !sync_ready && !sync_fail;
        in_sync    = (state_q == ST_SYNC);
        load       = (state_q == ST_IDLE) && start_i && (len_i != '0);
        step       = (state_q == ST_TARS) && phase_q[0] && !err_q && (left_q != LEN_W'(1));
    end

    lpc_addr_gen u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .base_i (addr_i),
        .step_i (step),
        .incr_i (incr_q),
        .addr_o (cur_addr)
    );

    lpc_sync_watch #(.LIMIT_W(LIMIT_W)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (in_sync),
        .stall_i  (sync_stall),
        .limit_i  (limit_q),
        .expire_o (expire)
    );

    lpc_drive_mux u_mux (
        .state_i    (state_q),
        .phase_i    (phase_q),
        .kind_i     (kind_q),
        .write_i    (wr_q),
        .addr_i     (cur_addr),
        .wbyte_i    (wbuf_q),
        .lad_o      (lad_o),
        .lad_oe_o   (lad_oe_o),
        .lframe_n_o (lframe_n_o)
    );

    // Sequencer: state, phase count, byte count, data buffers and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            phase_q  <= '0;
            left_q   <= '0;
            kind_q   <= KIND_IO;
            wr_q     <= 1'b0;
            incr_q   <= 1'b0;
            limit_q  <= '0;
            wbuf_q   <= '0;
            rlow_q   <= '0;
            err_q    <= 1'b0;
            done_q   <= 1'b0;
            rvalid_q <= 1'b0;
            rbyte_q  <= '0;
        end else begin
            done_q   <= 1'b0;
            rvalid_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    if (len_i == '0) begin
                        done_q <= 1'b1;
                        err_q  <= 1'b1;
                    end else begin
                        state_q <= ST_START;
                        err_q   <= 1'b0;
                        left_q  <= len_i;
                        kind_q  <= (cmd_kind_i == 2'd3) ? KIND_IO : cyc_kind_t'(cmd_kind_i);
                        wr_q    <= cmd_write_i;
                        incr_q  <= cmd_incr_i;
                        limit_q <= sync_limit_i;
                        phase_q <= '0;
                    end
                end
                ST_START: begin
                    if (wr_q) wbuf_q <= wr_byte_i;
                    state_q <= ST_TYPE;
                end
                ST_TYPE: begin
                    state_q <= ST_ADDR;
                    phase_q <= '0;
                end
                ST_ADDR: begin
                    if (phase_q == last_addr_nib(kind_q)) begin
                        phase_q <= '0;
                        if (kind_q == KIND_FWH) state_q <= ST_MSIZE;
                        else                    state_q <= wr_q ? ST_WDATA : ST_TARH;
                    end else begin
                        phase_q <= phase_q + 3'd1;
                    end
                end
                ST_MSIZE: state_q <= wr_q ? ST_WDATA : ST_TARH;
                ST_WDATA, ST_TARH: begin
                    if (phase_q[0]) begin
                        phase_q <= '0;
                        state_q <= (state_q == ST_WDATA) ? ST_TARH : ST_SYNC;
                    end else begin
                        phase_q <= 3'd1;
                    end
                end
                ST_SYNC: begin
                    phase_q <= '0;
                    if (sync_ready) begin
                        state_q <= wr_q ? ST_TARS : ST_RDATA;
                    end else if (sync_fail) begin
                        err_q   <= 1'b1;
                        state_q <= ST_TARS;
                    end else if (expire) begin
                        err_q   <= 1'b1;
                        state_q <= ST_ABORT;
                    end
                end
                ST_RDATA: begin
                    if (phase_q[0]) begin
                        rbyte_q  <= {lad_i, rlow_q};
                        rvalid_q <= 1'b1;
                        phase_q  <= '0;
                        state_q  <= ST_TARS;
                    end else begin
                        rlow_q  <= lad_i;
                        phase_q <= 3'd1;
                    end
                end
                ST_TARS: begin
                    if (phase_q[0]) begin
                        phase_q <= '0;
                        if (err_q || left_q == LEN_W'(1)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            left_q  <= left_q - LEN_W'(1);
                            state_q <= ST_START;
                        end
                    end else begin
                        phase_q <= 3'd1;
                    end
                end
                ST_ABORT: begin
                    if (phase_q == ABORT_LAST) begin
                        phase_q <= '0;
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        phase_q <= phase_q + 3'd1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output mapping.
    always_comb begin
        state_o    = state_q;
        wr_take_o  = (state_q == ST_START) && wr_q;
        rd_byte_o  = rbyte_q;
        rd_valid_o = rvalid_q;
        done_o     = done_q;
        error_o    = err_q;
    end

    // R3
    frame_only_start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n_o |-> (state_q == ST_START || state_q == ST_ABORT));

    // R8
    bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNC || state_q == ST_RDATA || state_q == ST_TARS) |-> !lad_oe_o);

    // R11
    abort_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ABORT && phase_q == ABORT_LAST) |=> (state_q == ST_IDLE && done_o && error_o));

    // R12
    empty_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i && len_i == '0) |=> (done_o && error_o && state_q == ST_IDLE));

    // R7
    rd_valid_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDATA && phase_q[0]) |=> (rd_valid_o && state_q == ST_TARS));

    // R8
    done_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state_q == ST_IDLE));

endmodule

// File: tb/test_lpc_cycle_engine.sv
module test_lpc_cycle_engine;

    logic        clk = 1'b0;
    logic        rst_n, start_i, cmd_write_i, cmd_incr_i;
    logic [1:0]  cmd_kind_i;
    logic [31:0] addr_i;
    logic [7:0]  len_i, sync_limit_i, wr_byte_i, rd_byte_o;
    logic [3:0]  lad_i, lad_o, state_o;
    logic        wr_take_o, rd_valid_o, done_o, error_o, lad_oe_o, lframe_n_o;

    always #10 clk = ~clk;

    lpc_cycle_engine i_lpc_cycle_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_write_i(cmd_write_i),
        .cmd_kind_i(cmd_kind_i), .cmd_incr_i(cmd_incr_i), .addr_i(addr_i),
        .len_i(len_i), .sync_limit_i(sync_limit_i), .wr_byte_i(wr_byte_i),
        .wr_take_o(wr_take_o), .rd_byte_o(rd_byte_o), .rd_valid_o(rd_valid_o),
        .done_o(done_o), .error_o(error_o), .state_o(state_o), .lad_o(lad_o),
        .lad_oe_o(lad_oe_o), .lframe_n_o(lframe_n_o), .lad_i(lad_i)
    );

    int checks = 0, fails = 0;
    logic [3:0] t_st[256], t_lad[256], e_st[256], e_lad[256];
    logic       t_oe[256], t_fr[256], e_oe[256];
    int         t_n, e_n, n_rd, n_take, s_waits;
    logic [3:0] s_final;
    logic [7:0] wdat[8], rdat[8], got_rd[8];
    bit         got_done;
    logic       got_err;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] st, input logic [3:0] nib, input logic oe);
        e_st[e_n] = st; e_lad[e_n] = nib; e_oe[e_n] = oe; e_n++;
    endtask

    // mode: 0 completes, 1 error sync, 2 timeout abort
    task automatic build_exp(input logic [1:0] kind, input bit wr, input bit incr,
                             input logic [31:0] addr, input int nb, input int waits,
                             input int mode, input int limit);
        e_n = 0;
        for (int b = 0; b < nb; b++) begin
            logic [31:0] a;
            int nn;
            a  = addr + (incr ? 32'(b) : 32'd0);
            nn = (kind == 2'd1) ? 8 : (kind == 2'd2) ? 7 : 4;
            push(4'd1, (kind == 2'd2) ? (wr ? 4'hE : 4'hD) : 4'h0, 1'b1);
            push(4'd2, (kind == 2'd2) ? a[31:28] : {1'b0, kind == 2'd1, wr, 1'b0}, 1'b1);
            for (int i = 0; i < nn; i++) begin
                logic [31:0] s;
                s = a >> (4 * (nn - 1 - i));
                push(4'd3, s[3:0], 1'b1);
            end
            if (kind == 2'd2) push(4'd4, 4'h0, 1'b1);
            if (wr) begin
                push(4'd5, wdat[b][3:0], 1'b1);
                push(4'd5, wdat[b][7:4], 1'b1);
            end
            push(4'd6, 4'hF, 1'b1);
            push(4'd6, 4'hF, 1'b0);
            if (mode == 2) begin
                for (int i = 0; i <= limit; i++) push(4'd7, 4'hF, 1'b0);
                for (int i = 0; i < 4; i++) push(4'd10, 4'hF, 1'b1);
                return;
            end
            for (int i = 0; i <= waits; i++) push(4'd7, 4'hF, 1'b0);
            if (mode == 0 && !wr) begin
                push(4'd8, 4'hF, 1'b0);
                push(4'd8, 4'hF, 1'b0);
            end
            push(4'd9, 4'hF, 1'b0);
            push(4'd9, 4'hF, 1'b0);
        end
    endtask

    // Issue a command and act as the slave until done.
    task automatic run(input logic [1:0] kind, input bit wr, input bit incr,
                       input logic [31:0] addr, input logic [7:0] len, input logic [7:0] limit);
        int widx = 0, sc = 0, rp = 0, rb = 0;
        bit took = 0;
        @(negedge clk);
        cmd_kind_i = kind; cmd_write_i = wr; cmd_incr_i = incr; addr_i = addr;
        len_i = len; sync_limit_i = limit; wr_byte_i = wdat[0]; lad_i = 4'hF; start_i = 1'b1;
        t_n = 0; n_rd = 0; n_take = 0; got_done = 0; got_err = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int cyc = 0; cyc < 400 && !got_done; cyc++) begin
            if (took) widx++;
            took = wr_take_o;
            if (wr_take_o) n_take++;
            wr_byte_i = wdat[widx[2:0]];
            if (rd_valid_o && n_rd < 8) begin got_rd[n_rd] = rd_byte_o; n_rd++; end
            if (done_o) begin
                got_done = 1; got_err = error_o;
            end else if (t_n < 256) begin
                t_st[t_n] = state_o; t_lad[t_n] = lad_o; t_oe[t_n] = lad_oe_o;
                t_fr[t_n] = lframe_n_o; t_n++;
            end
            if (state_o == 4'd7) begin
                lad_i = (sc < s_waits) ? (sc[0] ? 4'h6 : 4'h5) : s_final;
                sc++;
            end else begin
                sc = 0;
                if (state_o == 4'd8) begin
                    lad_i = (rp == 0) ? rdat[rb[2:0]][3:0] : rdat[rb[2:0]][7:4];
                    if (rp == 1) begin rp = 0; rb++; end else rp = 1;
                end else begin
                    lad_i = 4'hF;
                end
            end
            if (!got_done) @(negedge clk);
        end
        check(got_done, "R8", "done seen (watchdog)", 32'(got_done), 32'd1);
    endtask

    task automatic cmp_trace(input string req);
        int bad = -1;
        check(t_n == e_n, req, "trace length", 32'(t_n), 32'(e_n));
        for (int i = 0; i < t_n && i < e_n; i++) begin
            logic efr;
            efr = !(e_st[i] == 4'd1 || e_st[i] == 4'd10);
            if (bad < 0 && (t_st[i] != e_st[i] || t_oe[i] != e_oe[i] || t_fr[i] != efr ||
                            (e_oe[i] && t_lad[i] != e_lad[i])))
                bad = i;
        end
        if (bad >= 0)
            check(0, req, $sformatf("trace cycle %0d {state,lad,oe,frame}", bad),
                  {16'd0, t_st[bad], t_lad[bad], 3'd0, t_oe[bad], 3'd0, t_fr[bad]},
                  {16'd0, e_st[bad], e_lad[bad], 3'd0, e_oe[bad], 3'd0,
                   !(e_st[bad] == 4'd1 || e_st[bad] == 4'd10)});
        else
            check(1, req, "trace", 0, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start_i = 1'b0; cmd_write_i = 0; cmd_incr_i = 0; cmd_kind_i = 0;
        addr_i = 0; len_i = 0; sync_limit_i = 0; wr_byte_i = 0; lad_i = 4'hF;
        repeat (3) @(negedge clk);
        // R1 state during reset
        check(state_o == 4'd0 && lframe_n_o && !lad_oe_o && !done_o && !error_o &&
              !rd_valid_o && !wr_take_o, "R1", "outputs in reset",
              {state_o, lframe_n_o, lad_oe_o, done_o, error_o}, {4'd0, 4'b1000});
        rst_n = 1'b1;
        @(negedge clk);
        // R2 idle code after reset
        check(state_o == 4'd0 && lframe_n_o, "R2", "idle code", 32'(state_o), 32'd0);
    endtask

    task automatic t_io_write();
        wdat[0] = 8'hA5; s_waits = 0; s_final = 4'h0;
        run(2'd0, 1, 0, 32'h0000_12F8, 8'd1, 8'd4);
        build_exp(2'd0, 1, 0, 32'h0000_12F8, 1, 0, 0, 4);
        cmp_trace("R3 R4 R5 R6");
        check(n_take == 1, "R13", "write takes", 32'(n_take), 32'd1);
        check(!got_err, "R8", "no error", 32'(got_err), 0);
    endtask

    task automatic t_io_read_incr();
        rdat[0] = 8'h3C; rdat[1] = 8'hE1; s_waits = 2; s_final = 4'h0;
        // waits equal to the limit, ready on the last allowed clock
        run(2'd0, 0, 1, 32'h0000_03FF, 8'd2, 8'd2);
        build_exp(2'd0, 0, 1, 32'h0000_03FF, 2, 2, 0, 2);
        cmp_trace("R7 R9 R11");
        check(n_rd == 2, "R7", "read count", 32'(n_rd), 32'd2);
        check(got_rd[0] == 8'h3C && got_rd[1] == 8'hE1, "R7", "read bytes",
              {got_rd[0], got_rd[1]}, 32'h3CE1);
        check(!got_err, "R10", "waits no error", 32'(got_err), 0);
    endtask

    task automatic t_mem_write_single();
        wdat[0] = 8'h11; wdat[1] = 8'h2E; wdat[2] = 8'hF0; s_waits = 1; s_final = 4'h0;
        run(2'd1, 1, 0, 32'hDEAD_BEEF, 8'd3, 8'd5);
        build_exp(2'd1, 1, 0, 32'hDEAD_BEEF, 3, 1, 0, 5);
        cmp_trace("R5 R9");
        check(n_take == 3, "R13", "three takes", 32'(n_take), 32'd3);
    endtask

    task automatic t_fwh_read();
        rdat[0] = 8'h5A; s_waits = 0; s_final = 4'h0;
        run(2'd2, 0, 0, 32'h7123_4567, 8'd1, 8'd1);
        build_exp(2'd2, 0, 0, 32'h7123_4567, 1, 0, 0, 1);
        cmp_trace("R3 R4 R5");
        check(n_rd == 1 && got_rd[0] == 8'h5A, "R7", "fwh byte", 32'(got_rd[0]), 32'h5A);
        wdat[0] = 8'hC3;
        run(2'd2, 1, 0, 32'h2000_0010, 8'd1, 8'd1);
        build_exp(2'd2, 1, 0, 32'h2000_0010, 1, 0, 0, 1);
        cmp_trace("R3");
    endtask

    task automatic t_sync_error();
        s_waits = 3; s_final = 4'hA;
        run(2'd0, 0, 1, 32'h0000_0060, 8'd3, 8'd3);
        build_exp(2'd0, 0, 1, 32'h0000_0060, 1, 3, 1, 3);
        cmp_trace("R10");
        check(got_err, "R10", "error flag", 32'(got_err), 1);
        check(n_rd == 0, "R10", "no bytes", 32'(n_rd), 0);
    endtask

    task automatic t_timeout();
        s_waits = 1000; s_final = 4'h0;
        run(2'd1, 0, 0, 32'h0000_1000, 8'd2, 8'd3);
        build_exp(2'd1, 0, 0, 32'h0000_1000, 1, 0, 2, 3);
        cmp_trace("R11");
        check(got_err, "R11", "abort error", 32'(got_err), 1);
        @(negedge clk);
        // R13 error held while idle
        check(error_o && state_o == 4'd0, "R13", "error held", 32'(error_o), 1);
    endtask

    task automatic t_empty_then_clear();
        run(2'd0, 1, 0, 32'h0, 8'd0, 8'd1);
        check(t_n == 0, "R12", "no bus cycles", 32'(t_n), 0);
        check(got_err, "R12", "empty error", 32'(got_err), 1);
        wdat[0] = 8'h00; s_waits = 0; s_final = 4'h0;
        run(2'd0, 1, 0, 32'h0000_0080, 8'd1, 8'd0);
        check(!got_err, "R13", "error cleared", 32'(got_err), 0);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog R8 actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_io_write();
        t_io_read_incr();
        t_mem_write_single();
        t_fwh_read();
        t_sync_error();
        t_timeout();
        t_empty_then_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule